// File: doc/BRIEF.md
# Protection Key Access Checker

This block decides, for one translated data access per cycle, whether protection-key rules require a fault. It keeps a small table of sixteen 2-bit entries. The table is rebuilt from the control state, which is the long-paging-mode flag, the two key-enable flags (one for user addresses, one for supervisor addresses) and the write-protect flag. Each lookup indexes the table using the access-type bits, with the address type of the walk in the third index position. The chosen table entry is ANDed with the 2-bit rights entry that the leaf key selects from one of two 32-bit rights registers, so the decision needs no branching.

A page walker feeds the key from the leaf entry, the accumulated user/supervisor flag of the walk, the access bits, the present and reserved-fault bits, and the current contents of both rights registers. One cycle later the block returns a registered fault flag. Page walking, other permission faults and the rights-register write paths are handled elsewhere.

Top module: `pkey_fault_unit`

## Requirements
- R1: The key input selects rights bits 2k+1:2k of the chosen register for key k. Bit 2k+1 is write-disable and bit 2k is access-disable.
- R2: The rights register is chosen by address type. When `walk_user_i`=1 (U/S set in every walk level), `user_rights_i` is used. Otherwise `sup_rights_i` is used, whatever the access mode.
- R3: An access with `acc_fetch_i`=1 never faults.
- R4: An access with `present_i`=0 or `rsvd_fault_i`=1 never faults.
- R5: An enabled, present, non-fetch access faults when the selected access-disable bit is 1, regardless of write-protect or access kind.
- R6: If the selected write-disable bit is 1, a supervisor-mode write (`acc_user_i`=0) faults only when `wp_i`=1.
- R7: If the selected write-disable bit is 1, a user-mode write faults regardless of `wp_i`. A read never faults on write-disable alone.
- R8: With `long_mode_i`=0, or with both enables cleared, no access faults.
- R9: `ukey_en_i` gates only user addresses and `skey_en_i` gates only supervisor addresses.
- R10: `key_fault_o` is registered and reflects the lookup presented one clock earlier. The table is registered too, so a lookup in the same cycle as a control change uses the old table, and the new table applies from the next cycle.
- R11: Synchronous reset clears the table and `key_fault_o`. The first lookup after reset therefore cannot fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_mode_i | input | 1 | Long paging mode active |
| ukey_en_i | input | 1 | Key checks enabled for user addresses |
| skey_en_i | input | 1 | Key checks enabled for supervisor addresses |
| wp_i | input | 1 | Write-protect for supervisor accesses |
| key_i | input | 4 | Protection key from the leaf entry |
| walk_user_i | input | 1 | 1 when every walk level had U/S set |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| acc_user_i | input | 1 | Access made in user mode |
| acc_write_i | input | 1 | Access is a write |
| present_i | input | 1 | Translation present |
| rsvd_fault_i | input | 1 | Reserved-bit error seen during the walk |
| user_rights_i | input | 32 | Rights register for user addresses |
| sup_rights_i | input | 32 | Rights register for supervisor addresses |
| key_fault_o | output | 1 | Registered key-fault decision |

## Verification
A wrong table entry shows up only for the index it covers. It appears at `key_fault_o` one clock after a lookup that hits that index, and only if the rights entry bit it gates is set. A stale or early table shows up on the first lookup after a control change as a fault that comes one cycle too early or one cycle too late. The bench sweeps every control combination against every access-type and address-type pattern. It also walks every key position and rights value, so each table entry and rights slot is reached.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

  // Positions inside a 2-bit rights or table entry
  localparam int unsigned AD_POS = 0;
  localparam int unsigned WD_POS = 1;

  // Table index layout {fetch, addr_user, acc_user, acc_write}
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned IDX_WRITE = 0;
  localparam int unsigned IDX_AUSER = 1;
  localparam int unsigned IDX_ADDR  = 2;
  localparam int unsigned IDX_FETCH = 3;
  localparam int unsigned TBL_DEPTH = 1 << IDX_W;

  typedef struct packed {
    logic long_mode;
    logic ukey_en;
    logic skey_en;
    logic wp;
  } pk_ctrl_t;

  typedef logic [1:0] pk_pair_t;

  function automatic logic [IDX_W-1:0] make_index(input logic fetch,
                                                  input logic addr_user,
                                                  input logic acc_user,
                                                  input logic acc_write);
    logic [IDX_W-1:0] ix;
    ix            = '0;
    ix[IDX_FETCH] = fetch;
    ix[IDX_ADDR]  = addr_user;
    ix[IDX_AUSER] = acc_user;
    ix[IDX_WRITE] = acc_write;
    return ix;
  endfunction

endpackage

// File: rtl/pkey_mask_table.sv
module pkey_mask_table
  import pkey_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  pk_ctrl_t                 ctrl,
  input  logic [IDX_W-1:0]         rd_idx,
  output pk_pair_t                 rd_entry
);

  logic [2*TBL_DEPTH-1:0] tbl_q;

  genvar gi;
  generate
    for (gi = 0; gi < TBL_DEPTH; gi++) begin : g_entry
      localparam logic [IDX_W-1:0] IV = gi[IDX_W-1:0];
      logic     addr_on;
      pk_pair_t nxt;

      always_comb begin
        addr_on = ctrl.long_mode &
                  (IV[IDX_ADDR] ? ctrl.ukey_en : ctrl.skey_en);
        nxt = '0;
        if (addr_on && !IV[IDX_FETCH]) begin
          nxt[AD_POS] = 1'b1;
          nxt[WD_POS] = IV[IDX_WRITE] & (IV[IDX_AUSER] | ctrl.wp);
        end
      end

      always_ff @(posedge clk) begin
        if (rst) tbl_q[2*gi +: 2] <= '0;
        else     tbl_q[2*gi +: 2] <= nxt;
      end
    end
  endgenerate

  assign rd_entry = tbl_q[{rd_idx, 1'b0} +: 2];

  // Fetch slots stay empty one cycle after any control state
  AST_FETCH_SLOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rd_idx[IDX_FETCH] |-> (rd_entry == 2'b00)); // R3

endmodule

// File: rtl/pkey_rights_pick.sv
module pkey_rights_pick
  import pkey_pkg::*;
#(
  parameter int unsigned NUM_KEYS = 16,
  localparam int unsigned KEY_W   = $clog2(NUM_KEYS),
  localparam int unsigned RIGHTS_W = 2 * NUM_KEYS
) (
  input  logic [KEY_W-1:0]    key,
  input  logic                addr_user,
  input  logic [RIGHTS_W-1:0] user_rights,
  input  logic [RIGHTS_W-1:0] sup_rights,
  output pk_pair_t            entry
);

  logic [RIGHTS_W-1:0] chosen;

  always_comb begin
    chosen = addr_user ? user_rights : sup_rights;
    entry  = chosen[{key, 1'b0} +: 2];
  end

endmodule

// File: rtl/pkey_fault_eval.sv
module pkey_fault_eval
  import pkey_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pk_pair_t tbl_entry,
  input  pk_pair_t rights_entry,
  input  logic     present,
  input  logic     rsvd_fault,
  output logic     fault_q
);

  logic     eligible;
  pk_pair_t hit;
  logic     fault_d;

  always_comb begin
    eligible = present & ~rsvd_fault;
    hit      = tbl_entry & rights_entry;
    fault_d  = eligible & (hit[AD_POS] | hit[WD_POS]);
  end

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= fault_d;
  end

  AST_TERMINAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!present || rsvd_fault) |=> !fault_q); // R4

endmodule

// File: rtl/pkey_fault_unit.sv
module pkey_fault_unit
  import pkey_pkg::*;
#(
  parameter int unsigned NUM_KEYS = 16,
  localparam int unsigned KEY_W   = $clog2(NUM_KEYS),
  localparam int unsigned RIGHTS_W = 2 * NUM_KEYS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                long_mode_i,
  input  logic                ukey_en_i,
  input  logic                skey_en_i,
  input  logic                wp_i,
  input  logic [KEY_W-1:0]    key_i,
  input  logic                walk_user_i,
  input  logic                acc_fetch_i,
  input  logic                acc_user_i,
  input  logic                acc_write_i,
  input  logic                present_i,
  input  logic                rsvd_fault_i,
  input  logic [RIGHTS_W-1:0] user_rights_i,
  input  logic [RIGHTS_W-1:0] sup_rights_i,
  output logic                key_fault_o
);

  pk_ctrl_t         ctrl;
  logic [IDX_W-1:0] idx;
  pk_pair_t         tbl_entry;
  pk_pair_t         rights_entry;

  always_comb begin
    ctrl.long_mode = long_mode_i;
    ctrl.ukey_en   = ukey_en_i;
    ctrl.skey_en   = skey_en_i;
    ctrl.wp        = wp_i;
    idx = make_index(acc_fetch_i, walk_user_i, acc_user_i, acc_write_i);
  end

  pkey_mask_table u_table (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .rd_idx   (idx),
    .rd_entry (tbl_entry)
  );

  pkey_rights_pick #(.NUM_KEYS(NUM_KEYS)) u_pick (
    .key         (key_i),
    .addr_user   (walk_user_i),
    .user_rights (user_rights_i),
    .sup_rights  (sup_rights_i),
    .entry       (rights_entry)
  );

  pkey_fault_eval u_eval (
    .clk          (clk),
    .rst          (rst),
    .tbl_entry    (tbl_entry),
    .rights_entry (rights_entry),
    .present      (present_i),
    .rsvd_fault   (rsvd_fault_i),
    .fault_q      (key_fault_o)
  );

  AST_FETCH_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    acc_fetch_i |=> !key_fault_o); // R3

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(long_mode_i) |=> !key_fault_o); // R8

  AST_SUP_WRITE_NO_WP: assert property (@(posedge clk) disable iff (rst)
    (!acc_user_i && !$past(wp_i) && !rights_entry[AD_POS]) |=> !key_fault_o); // R6

  AST_READ_NO_WD: assert property (@(posedge clk) disable iff (rst)
    (!acc_write_i && !rights_entry[AD_POS]) |=> !key_fault_o); // R7

endmodule

// File: tb/pkey_fault_unit_test.sv
module pkey_fault_unit_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic long_mode_i = 0, ukey_en_i = 0, skey_en_i = 0, wp_i = 0;
  logic [3:0] key_i = '0;
  logic walk_user_i = 0, acc_fetch_i = 0, acc_user_i = 0, acc_write_i = 0;
  logic present_i = 0, rsvd_fault_i = 0;
  logic [31:0] user_rights_i = '0, sup_rights_i = '0;
  logic key_fault_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #10 clk = ~clk; // 50 MHz

  pkey_fault_unit uut (
    .clk(clk), .rst(rst),
    .long_mode_i(long_mode_i), .ukey_en_i(ukey_en_i), .skey_en_i(skey_en_i), .wp_i(wp_i),
    .key_i(key_i), .walk_user_i(walk_user_i),
    .acc_fetch_i(acc_fetch_i), .acc_user_i(acc_user_i), .acc_write_i(acc_write_i),
    .present_i(present_i), .rsvd_fault_i(rsvd_fault_i),
    .user_rights_i(user_rights_i), .sup_rights_i(sup_rights_i),
    .key_fault_o(key_fault_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] nxt_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Reference decision from current inputs and the controls in force
  function automatic bit model(input bit lm, input bit eu, input bit es, input bit wp,
                               input logic [3:0] k, input bit wu, input bit f,
                               input bit au, input bit aw, input bit pr, input bit rv,
                               input logic [31:0] ur, input logic [31:0] sr);
    logic [31:0] r;
    logic [1:0]  e;
    bit en;
    r  = wu ? ur : sr;
    e  = r[2*k +: 2];
    en = lm && (wu ? eu : es);
    if (!pr || rv || f || !en) return 0;
    return e[0] || (e[1] && aw && (au || wp));
  endfunction

  task automatic check(input string req, input bit exp);
    total++;
    if (key_fault_o !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b key=%0d wu=%0b f=%0b au=%0b aw=%0b",
               req, key_fault_o, exp, key_i, walk_user_i, acc_fetch_i, acc_user_i, acc_write_i);
    end
  endtask

  task automatic set_ctrl(input logic [3:0] c);
    {long_mode_i, ukey_en_i, skey_en_i, wp_i} = c;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic lookup(input string req, input logic [3:0] k, input logic [5:0] a,
                        input logic [31:0] ur, input logic [31:0] sr);
    bit exp;
    key_i = k;
    {walk_user_i, acc_fetch_i, acc_user_i, acc_write_i, present_i, rsvd_fault_i} = a;
    user_rights_i = ur; sup_rights_i = sr;
    exp = model(long_mode_i, ukey_en_i, skey_en_i, wp_i, k, a[5], a[4], a[3], a[2],
                a[1], a[0], ur, sr);
    @(posedge clk); @(negedge clk);
    check(req, exp);
  endtask

  initial begin
    // R11: reset state, then a would-fault lookup right after release
    repeat (3) @(negedge clk);
    check("R11 reset", 1'b0);
    {long_mode_i, ukey_en_i, skey_en_i, wp_i} = 4'hF;
    key_i = 4'd2; walk_user_i = 1; present_i = 1; user_rights_i = 32'hFFFF_FFFF;
    rst = 0;
    @(posedge clk); @(negedge clk);
    check("R11 first lookup", 1'b0);
    @(posedge clk); @(negedge clk);
    check("R11 table loaded", 1'b1);

    // R3 R4 R5 R6 R7 R8 R9: every control state against every access pattern
    for (int c = 0; c < 16; c++) begin
      set_ctrl(c[3:0]);
      for (int a = 0; a < 64; a++) begin
        seed = nxt_rand(seed);
        lookup("R3-R9 sweep", 4'((c * 5 + a) % 16), a[5:0], seed, ~{seed[15:0], seed[31:16]});
      end
    end

    // R1 R2: each key slot with each value, other slots holding the complement
    set_ctrl(4'hF);
    for (int k = 0; k < 16; k++) begin
      for (int v = 0; v < 4; v++) begin
        logic [31:0] pat;
        pat = '0;
        for (int j = 0; j < 16; j++) pat[2*j +: 2] = (j == k) ? v[1:0] : ~v[1:0];
        for (int wu = 0; wu < 2; wu++) begin
          lookup("R1 slot", k[3:0], {wu[0], 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, pat, pat);
          lookup("R2 user reg", k[3:0], {wu[0], 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
                 wu[0] ? pat : 32'h0, wu[0] ? 32'h0 : pat);
          lookup("R2 sup reg", k[3:0], {wu[0], 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
                 wu[0] ? 32'h0 : pat, wu[0] ? pat : 32'h0);
        end
      end
    end

    // R10: control change lands with a lookup in the same cycle
    key_i = 4'd3; walk_user_i = 1; acc_fetch_i = 0; acc_user_i = 1; acc_write_i = 0;
    present_i = 1; rsvd_fault_i = 0; user_rights_i = 32'h0000_0040; sup_rights_i = '0;
    @(posedge clk); @(negedge clk);
    check("R10 steady on", 1'b1);
    long_mode_i = 0;
    @(posedge clk); @(negedge clk);
    check("R10 old table used", 1'b1);
    @(posedge clk); @(negedge clk);
    check("R10 new table off", 1'b0);
    long_mode_i = 1;
    @(posedge clk); @(negedge clk);
    check("R10 old table off", 1'b0);
    @(posedge clk); @(negedge clk);
    check("R10 new table on", 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule